// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block collects event pulses from an ADC and a set of timers and turns them into vector calls for a small microcontroller core. The ADC boundary compare has a vector of its own. The remaining sources are placed in shared groups, and each group has one vector. The ADC end-of-conversion and end-of-scan events form one group. The compare-P and compare-A matches of each timer form another group, one group per timer.

Flags are kept at two levels. Each shared source has a sticky request flag that only a software write clears. Each vector has a group request flag that the controller clears itself when the vector is serviced. A call is requested only when four things hold: the global enable is set, the source was enabled when its event arrived, the vector's group enable is set, and the stack is not full. When the CPU acknowledges a call, the controller does three things. It clears the global enable, so that calls do not nest. It clears the serviced group flag. It emits a one-cycle pulse that carries the vector index. A return-from-interrupt strobe sets the global enable again.

Top module: `grp_irq_ctrl`

## Requirements
- R1: A boundary hit is taken only in a cycle with `adc_valid` high. `cmp_mode` 2'b10 hits when `adc_value > hi_bound`. 2'b01 hits when `adc_value < lo_bound`. 2'b11 hits on either condition. 2'b00 never hits. A hit sets group flag 0 (vector 0) at the next clock edge. A value equal to a bound does not hit.
- R2: Source flag bits are laid out as follows: bit 0 end-of-conversion, bit 1 end-of-scan, bit 2+2t timer t compare-P, bit 3+2t timer t compare-A. An event pulse sets its flag at the next edge. A `src_clr` bit clears the flag. When an event and a clear arrive in the same cycle, the flag ends up set.
- R3: Shared group g (g ≥ 1, vector g) holds source bits 2g-2 and 2g-1. The group flag is set only by an event on one of those sources that arrives while the source's `src_en` bit is 1. An event with the enable at 0 sets the source flag only.
- R4: `irq_req` is high only while `gie` is 1, `stack_full` is 0, and at least one group flag has its `grp_en` bit set.
- R5: When several vectors are pending, `irq_vec` gives the lowest pending vector index.
- R6: `cpu_ack` while `irq_req` is high has three effects at the next edge. `gie` goes to 0. The group flag of `irq_vec` is cleared, unless that group gets a new set in the same cycle. `svc_pulse` is high for exactly one cycle, with `svc_vec` equal to the serviced index.
- R7: Servicing a vector leaves every source flag unchanged.
- R8: `reti` sets `gie` at the next edge. `gie_wr` loads `gie_wdata` into `gie`. An acknowledge in the same cycle overrides both, and `reti` overrides `gie_wr`.
- R9: After reset, `gie`, all flags, `irq_req` and `svc_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_valid | input | 1 | Conversion result valid strobe |
| adc_value | input | DATA_W | Converted value |
| hi_bound | input | DATA_W | Upper boundary |
| lo_bound | input | DATA_W | Lower boundary |
| cmp_mode | input | 2 | Boundary comparison select |
| adc_eoc_evt | input | 1 | End-of-conversion event pulse |
| adc_scan_evt | input | 1 | End-of-scan event pulse |
| tmr_p_evt | input | NUM_TMR | Timer compare-P match pulses |
| tmr_a_evt | input | NUM_TMR | Timer compare-A match pulses |
| src_en | input | NUM_SRC | Per-source enables |
| src_clr | input | NUM_SRC | Software clear strobes for source flags |
| grp_en | input | NUM_GRP | Per-vector group enables |
| gie_wr | input | 1 | Global enable write strobe |
| gie_wdata | input | 1 | Global enable write value |
| reti | input | 1 | Return-from-interrupt strobe |
| stack_full | input | 1 | Call stack full |
| cpu_ack | input | 1 | CPU accepts the requested vector |
| irq_req | output | 1 | Vector call request |
| irq_vec | output | VEC_W | Requested vector index |
| svc_pulse | output | 1 | One-cycle service pulse |
| svc_vec | output | VEC_W | Serviced vector index |
| gie | output | 1 | Global enable state |
| src_flag | output | NUM_SRC | Source request flags |
| grp_flag | output | NUM_GRP | Group request flags |

## Verification
The hardest case to reach from the ports is a service acknowledge that coincides with a fresh hardware event on the group being serviced. It has to be shown that the set wins, while the global enable still drops. To get there, the stimulus first builds two pending vectors and services the lower one. It then re-opens the global enable with `reti`, so that the timer vector becomes the one requested. Finally it drives `cpu_ack` and that timer's compare-P pulse in the same cycle, then reads the group flags and `gie` back.

// File: rtl/grp_irq_pkg.sv
package grp_irq_pkg;
   typedef enum logic [1:0] {
      CMP_OFF  = 2'b00,
      CMP_LO   = 2'b01,
      CMP_HI   = 2'b10,
      CMP_BOTH = 2'b11
   } cmp_mode_e;

   function automatic int vec_w(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/bnd_cmp.sv
module bnd_cmp #(
   parameter int DATA_W    = 10,
   parameter bit INCLUSIVE = 1'b0
) (
   input  logic              valid,
   input  logic [DATA_W-1:0] value,
   input  logic [DATA_W-1:0] hi_bound,
   input  logic [DATA_W-1:0] lo_bound,
   input  logic [1:0]        mode,
   output logic              hit
);
   logic above;
   logic below;

   generate
      if (INCLUSIVE) begin : g_incl
         assign above = (value >= hi_bound);
         assign below = (value <= lo_bound);
      end else begin : g_strict
         assign above = (value > hi_bound);
         assign below = (value < lo_bound);
      end
   endgenerate

   assign hit = valid & ((mode[1] & above) | (mode[0] & below));
endmodule

// File: rtl/flag_bank.sv
module flag_bank #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] q
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      q[i] <= 1'b0;
            else if (set[i]) q[i] <= 1'b1;
            else if (clr[i]) q[i] <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
   parameter int N = 4,
   parameter int W = 2
) (
   input  logic [N-1:0] req,
   output logic         any,
   output logic [W-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = W'(i);
      end
   end
   assign any = |req;
endmodule

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl
   import grp_irq_pkg::*;
#(
   parameter int NUM_TMR       = 2,
   parameter int DATA_W        = 10,
   parameter bit BND_INCLUSIVE = 1'b0,
   localparam int NUM_SRC      = 2 + 2 * NUM_TMR,
   localparam int NUM_GRP      = 2 + NUM_TMR,
   localparam int VEC_W        = vec_w(NUM_GRP)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               adc_valid,
   input  logic [DATA_W-1:0]  adc_value,
   input  logic [DATA_W-1:0]  hi_bound,
   input  logic [DATA_W-1:0]  lo_bound,
   input  logic [1:0]         cmp_mode,
   input  logic               adc_eoc_evt,
   input  logic               adc_scan_evt,
   input  logic [NUM_TMR-1:0] tmr_p_evt,
   input  logic [NUM_TMR-1:0] tmr_a_evt,
   input  logic [NUM_SRC-1:0] src_en,
   input  logic [NUM_SRC-1:0] src_clr,
   input  logic [NUM_GRP-1:0] grp_en,
   input  logic               gie_wr,
   input  logic               gie_wdata,
   input  logic               reti,
   input  logic               stack_full,
   input  logic               cpu_ack,
   output logic               irq_req,
   output logic [VEC_W-1:0]   irq_vec,
   output logic               svc_pulse,
   output logic [VEC_W-1:0]   svc_vec,
   output logic               gie,
   output logic [NUM_SRC-1:0] src_flag,
   output logic [NUM_GRP-1:0] grp_flag
);
   if (NUM_TMR < 1) begin : g_bad_tmr
      $error("NUM_TMR must be at least 1");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be at least 2");
   end

   logic [NUM_SRC-1:0] src_evt;
   logic [NUM_GRP-1:0] grp_set;
   logic [NUM_GRP-1:0] grp_clr;
   logic [NUM_GRP-1:0] pend;
   logic               bnd_hit;
   logic               any_pend;
   logic [VEC_W-1:0]   pick;
   logic               take;

   assign src_evt[0] = adc_eoc_evt;
   assign src_evt[1] = adc_scan_evt;

   generate
      for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr_map
         assign src_evt[2 + 2 * t] = tmr_p_evt[t];
         assign src_evt[3 + 2 * t] = tmr_a_evt[t];
      end
   endgenerate

   bnd_cmp #(
      .DATA_W   (DATA_W),
      .INCLUSIVE(BND_INCLUSIVE)
   ) u_bnd (
      .valid   (adc_valid),
      .value   (adc_value),
      .hi_bound(hi_bound),
      .lo_bound(lo_bound),
      .mode    (cmp_mode),
      .hit     (bnd_hit)
   );

   flag_bank #(.N(NUM_SRC)) u_src (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (src_evt),
      .clr  (src_clr),
      .q    (src_flag)
   );

   assign grp_set[0] = bnd_hit;
   generate
      for (genvar g = 1; g < NUM_GRP; g++) begin : g_grp_set
         assign grp_set[g] = |(src_evt[2*g-1 -: 2] & src_en[2*g-1 -: 2]);
      end
   endgenerate

   assign pend    = grp_flag & grp_en;
   assign irq_req = gie & ~stack_full & any_pend;
   assign irq_vec = pick;
   assign take    = cpu_ack & irq_req;

   prio_pick #(.N(NUM_GRP), .W(VEC_W)) u_pick (
      .req(pend),
      .any(any_pend),
      .idx(pick)
   );

   always_comb begin
      grp_clr = '0;
      if (take) grp_clr[pick] = 1'b1;
   end

   flag_bank #(.N(NUM_GRP)) u_grp (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (grp_set),
      .clr  (grp_clr),
      .q    (grp_flag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gie       <= 1'b0;
         svc_pulse <= 1'b0;
         svc_vec   <= '0;
      end else begin
         svc_pulse <= take;
         if (take) svc_vec <= pick;
         if (take)        gie <= 1'b0;
         else if (reti)   gie <= 1'b1;
         else if (gie_wr) gie <= gie_wdata;
      end
   end
endmodule

// File: rtl/grp_irq_chk.sv
module grp_irq_chk #(
   parameter int NUM_TMR = 2,
   localparam int NUM_SRC = 2 + 2 * NUM_TMR,
   localparam int NUM_GRP = 2 + NUM_TMR,
   localparam int VEC_W   = grp_irq_pkg::vec_w(NUM_GRP)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               adc_eoc_evt,
   input logic [NUM_SRC-1:0] src_clr,
   input logic [NUM_GRP-1:0] grp_en,
   input logic               gie_wr,
   input logic               reti,
   input logic               stack_full,
   input logic               cpu_ack,
   input logic               irq_req,
   input logic [VEC_W-1:0]   irq_vec,
   input logic               svc_pulse,
   input logic               gie,
   input logic [NUM_SRC-1:0] src_flag,
   input logic [NUM_GRP-1:0] grp_flag
);
   AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (gie && !stack_full && grp_flag[irq_vec] && grp_en[irq_vec])); // R4

   AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && irq_vec != '0) |-> !(grp_flag[0] && grp_en[0])); // R5

   AST_ACK_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ack && irq_req) |=> (!gie && svc_pulse)); // R6

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      svc_pulse |=> !svc_pulse); // R6

   AST_SRC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (src_flag[0] && !src_clr[0]) |=> src_flag[0]); // R7

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      adc_eoc_evt |=> src_flag[0]); // R2

   AST_RETI_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (reti && !(cpu_ack && irq_req)) |=> gie); // R8

   AST_NOT_HALF_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gie) |-> ($past(reti) || $past(gie_wr))); // R8
endmodule

bind grp_irq_ctrl grp_irq_chk #(.NUM_TMR(NUM_TMR)) u_chk (.*);

// File: tb/sim_grp_irq_ctrl.sv
`timescale 1ns/1ps
module sim_grp_irq_ctrl;
   localparam int NT = 2;
   localparam int NS = 2 + 2 * NT;
   localparam int NG = 2 + NT;
   localparam int VW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic adc_valid = 1'b0;
   logic [9:0] adc_value = '0, hi_bound = 10'd500, lo_bound = 10'd100;
   logic [1:0] cmp_mode = 2'b00;
   logic adc_eoc_evt = 1'b0, adc_scan_evt = 1'b0;
   logic [NT-1:0] tmr_p_evt = '0, tmr_a_evt = '0;
   logic [NS-1:0] src_en = '0, src_clr = '0;
   logic [NG-1:0] grp_en = '0;
   logic gie_wr = 1'b0, gie_wdata = 1'b0, reti = 1'b0, stack_full = 1'b0, cpu_ack = 1'b0;
   logic irq_req, svc_pulse, gie;
   logic [VW-1:0] irq_vec, svc_vec;
   logic [NS-1:0] src_flag;
   logic [NG-1:0] grp_flag;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   grp_irq_ctrl #(.NUM_TMR(NT), .DATA_W(10)) u0 (.*);

   localparam int TV_N = 8;
   localparam logic [9:0] TV_VAL [TV_N] = '{10'd600, 10'd600, 10'd50, 10'd50,
                                            10'd500, 10'd100, 10'd700, 10'd20};
   localparam logic [1:0] TV_MODE [TV_N] = '{2'b10, 2'b01, 2'b01, 2'b10,
                                             2'b11, 2'b11, 2'b00, 2'b11};
   localparam logic TV_EXP [TV_N] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic clear_bnd();
      grp_en = 4'b0001;
      gie_wr = 1'b1;
      gie_wdata = 1'b1;
      cyc();
      gie_wr = 1'b0;
      cpu_ack = 1'b1;
      cyc();
      cpu_ack = 1'b0;
      grp_en = '0;
      cyc();
   endtask

   initial begin
      #200000;
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9 gie", 32'(gie), 0);
      chk("R9 src_flag", 32'(src_flag), 0);
      chk("R9 grp_flag", 32'(grp_flag), 0);
      chk("R9 irq_req", 32'(irq_req), 0);
      rst_n = 1'b1;
      cyc();
      chk("R9 svc_pulse", 32'(svc_pulse), 0);

      // R1 boundary compare table
      for (int i = 0; i < TV_N; i++) begin
         adc_value = TV_VAL[i];
         cmp_mode  = TV_MODE[i];
         adc_valid = 1'b1;
         cyc();
         adc_valid = 1'b0;
         chk($sformatf("R1 vec%0d grp_flag0", i), 32'(grp_flag[0]), 32'(TV_EXP[i]));
         if (grp_flag[0]) clear_bnd();
      end

      // R1 no hit without valid
      adc_value = 10'd900;
      cmp_mode = 2'b11;
      cyc();
      chk("R1 no valid", 32'(grp_flag[0]), 0);

      // R2 set and clear, R3 disabled source
      adc_eoc_evt = 1'b1;
      cyc();
      adc_eoc_evt = 1'b0;
      chk("R2 eoc set", 32'(src_flag[0]), 1);
      chk("R3 disabled eoc no group", 32'(grp_flag[1]), 0);
      src_clr = 6'b000001;
      cyc();
      src_clr = '0;
      chk("R2 eoc cleared", 32'(src_flag[0]), 0);
      src_clr = 6'b000001;
      adc_eoc_evt = 1'b1;
      cyc();
      adc_eoc_evt = 1'b0;
      src_clr = '0;
      chk("R2 set wins", 32'(src_flag[0]), 1);
      src_clr = 6'b000001;
      cyc();
      src_clr = '0;

      // R3 enabled timer P
      src_en = 6'b000100;
      tmr_p_evt = 2'b01;
      cyc();
      tmr_p_evt = '0;
      chk("R3 grp flags", 32'(grp_flag), 32'h4);
      chk("R3 src flag tp0", 32'(src_flag), 32'h4);

      // R4 gating
      grp_en = 4'b0110;
      cyc();
      chk("R4 gie off", 32'(irq_req), 0);
      gie_wr = 1'b1;
      gie_wdata = 1'b1;
      stack_full = 1'b1;
      cyc();
      gie_wr = 1'b0;
      chk("R8 gie write", 32'(gie), 1);
      chk("R4 stack full", 32'(irq_req), 0);
      stack_full = 1'b0;
      cyc();
      chk("R4 req", 32'(irq_req), 1);
      chk("R4 vec", 32'(irq_vec), 2);

      // R5 lower vector wins
      src_en = 6'b000110;
      adc_scan_evt = 1'b1;
      cyc();
      adc_scan_evt = 1'b0;
      chk("R5 vec", 32'(irq_vec), 1);

      // R6 service
      cpu_ack = 1'b1;
      cyc();
      cpu_ack = 1'b0;
      chk("R6 pulse", 32'(svc_pulse), 1);
      chk("R6 svc_vec", 32'(svc_vec), 1);
      chk("R6 gie cleared", 32'(gie), 0);
      chk("R6 grp cleared", 32'(grp_flag), 32'h4);
      chk("R6 req drop", 32'(irq_req), 0);
      cyc();
      chk("R6 pulse single", 32'(svc_pulse), 0);
      chk("R7 src kept", 32'(src_flag), 32'h6);

      // R8 reti
      reti = 1'b1;
      cyc();
      reti = 1'b0;
      chk("R8 reti gie", 32'(gie), 1);
      chk("R8 reti vec", 32'(irq_vec), 2);

      // R6 ack coinciding with new set on same group
      cpu_ack = 1'b1;
      tmr_p_evt = 2'b01;
      cyc();
      cpu_ack = 1'b0;
      tmr_p_evt = '0;
      chk("R6 set beats service", 32'(grp_flag[2]), 1);
      chk("R6 gie off after ack", 32'(gie), 0);
      chk("R6 svc_vec timer", 32'(svc_vec), 2);

      // R8 write zero
      gie_wr = 1'b1;
      gie_wdata = 1'b1;
      cyc();
      chk("R8 write one", 32'(gie), 1);
      gie_wdata = 1'b0;
      cyc();
      gie_wr = 1'b0;
      chk("R8 write zero", 32'(gie), 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule